// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block generates the horizontal and vertical raster position of a display, together with an active-area flag, horizontal and vertical sync, a composite sync for the colour channels, and a once-per-line strobe that tells a pixel fetch engine to start on the next line. A host sets every interval through a small register write port. Each timing register holds the last index of an interval (a length minus one), not a length. The counters run only while two enable bits are set. Software clears them, reprograms the geometry, and sets them again. The raster then restarts from position zero.

A sync configuration register picks the sync polarity and can hold either sync, or both, at their inactive level for power-saving blanking. A separate output configuration bit turns off the video-enable output while the syncs keep running. Changes to any register take effect on the clock edge that follows the write.

Top module: `dtg_top`

## Requirements
- R1: After synchronous reset all registers are zero, both counters read 0, and `active`, `video_en`, `prefetch`, `rgb_sync`, `hsync` and `vsync` are all 0.
- R2: The counters advance only while bits 0 and 1 of the run register (address 0) are both 1. While either bit is 0, both counters are cleared to 0 on each clock, and `active` and `prefetch` stay low.
- R3: While running, `h_pos` counts from 0 up to the horizontal last-pixel register (address 1) and then returns to 0. `v_pos` advances by one only on that return, and goes back to 0 after it reaches the vertical last-line register (address 5).
- R4: `active` is 1 exactly when the block is running, `h_pos` is at most the horizontal active-last register (address 2), and `v_pos` is at most the vertical active-last register (address 6).
- R5: The uninverted horizontal sync is 1 while `h_pos` lies between the registers at addresses 3 (first) and 4 (last), both ends included. The uninverted vertical sync follows the same rule on `v_pos`, using addresses 7 and 8.
- R6: `prefetch` is 1 for the single cycle in each line when `h_pos` equals the fetch position register (address 9).
- R7: In the sync configuration register (address 10), bit 3 inverts `hsync` and bit 4 inverts `vsync`. An inverted sync idles at 1.
- R8: Bit 5 of address 10 holds `hsync` at its inactive level, bit 6 does the same for `vsync`, and bit 1 does it for both.
- R9: When bit 0 of address 10 is set, `rgb_sync` is 1 whenever an unsuppressed uninverted sync (horizontal or vertical) is active. Otherwise `rgb_sync` is 0.
- R10: Bit 1 of the output configuration register (address 11) forces `video_en` to 0. With that bit clear, `video_en` equals `active`. Sync generation is unaffected either way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register select |
| reg_wdata | input | 16 | Register write value |
| h_pos | output | CNT_W | Horizontal position |
| v_pos | output | CNT_W | Vertical position |
| active | output | 1 | Position lies inside the visible area |
| video_en | output | 1 | Active and not force-blanked |
| hsync | output | 1 | Horizontal sync after polarity and suppression |
| vsync | output | 1 | Vertical sync after polarity and suppression |
| rgb_sync | output | 1 | Composite sync for the colour channels |
| prefetch | output | 1 | One-cycle per-line fetch strobe |

## Verification
The assertions check, on every cycle, several invariants that hold for any programming:
- the counters clear while stopped;
- the horizontal counter returns to zero after its last index;
- the vertical counter moves only on a horizontal return;
- the fetch strobe never lasts two cycles;
- `video_en` never rises outside the active area;
- the all-off bit holds both syncs at their idle levels.

Only the bench scenarios can show that the sync and active windows land on the exact positions set in the registers. The same applies to the per-bit polarity and suppression effects, and to composite sync on the colour channels. Each of these needs a known programmed mode and a known cycle count from start.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 16;

    // register select values
    localparam logic [ADDR_W-1:0] SEL_RUN      = 4'd0;
    localparam logic [ADDR_W-1:0] SEL_H_LAST   = 4'd1;
    localparam logic [ADDR_W-1:0] SEL_H_ACT    = 4'd2;
    localparam logic [ADDR_W-1:0] SEL_HS_FIRST = 4'd3;
    localparam logic [ADDR_W-1:0] SEL_HS_LAST  = 4'd4;
    localparam logic [ADDR_W-1:0] SEL_V_LAST   = 4'd5;
    localparam logic [ADDR_W-1:0] SEL_V_ACT    = 4'd6;
    localparam logic [ADDR_W-1:0] SEL_VS_FIRST = 4'd7;
    localparam logic [ADDR_W-1:0] SEL_VS_LAST  = 4'd8;
    localparam logic [ADDR_W-1:0] SEL_FETCH    = 4'd9;
    localparam logic [ADDR_W-1:0] SEL_SYNC     = 4'd10;
    localparam logic [ADDR_W-1:0] SEL_OUT      = 4'd11;

    // geometry of one axis, all values are last indices
    typedef struct packed {
        logic [DATA_W-1:0] last;
        logic [DATA_W-1:0] act_last;
        logic [DATA_W-1:0] sync_first;
        logic [DATA_W-1:0] sync_last;
    } axis_cfg_t;

    typedef struct packed {
        logic rgb_en;
        logic all_off;
        logic hs_inv;
        logic vs_inv;
        logic hs_off;
        logic vs_off;
    } sync_cfg_t;

    function automatic sync_cfg_t unpack_sync(input logic [DATA_W-1:0] raw);
        sync_cfg_t c;
        c.rgb_en  = raw[0];
        c.all_off = raw[1];
        c.hs_inv  = raw[3];
        c.vs_inv  = raw[4];
        c.hs_off  = raw[5];
        c.vs_off  = raw[6];
        return c;
    endfunction

    function automatic logic in_span(input logic [DATA_W-1:0] x,
                                     input logic [DATA_W-1:0] lo,
                                     input logic [DATA_W-1:0] hi);
        return (x >= lo) && (x <= hi);
    endfunction

endpackage

// File: rtl/dtg_regs.sv
module dtg_regs
    import dtg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              run,
    output axis_cfg_t         h_cfg,
    output axis_cfg_t         v_cfg,
    output logic [DATA_W-1:0] fetch_pos,
    output sync_cfg_t         sync_cfg,
    output logic              force_blank
);
    logic [1:0]        run_q;
    logic [DATA_W-1:0] sync_q;
    logic [DATA_W-1:0] out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q     <= '0;
            h_cfg     <= '0;
            v_cfg     <= '0;
            fetch_pos <= '0;
            sync_q    <= '0;
            out_q     <= '0;
        end else if (we) begin
            case (addr)
                SEL_RUN:      run_q            <= wdata[1:0];
                SEL_H_LAST:   h_cfg.last       <= wdata;
                SEL_H_ACT:    h_cfg.act_last   <= wdata;
                SEL_HS_FIRST: h_cfg.sync_first <= wdata;
                SEL_HS_LAST:  h_cfg.sync_last  <= wdata;
                SEL_V_LAST:   v_cfg.last       <= wdata;
                SEL_V_ACT:    v_cfg.act_last   <= wdata;
                SEL_VS_FIRST: v_cfg.sync_first <= wdata;
                SEL_VS_LAST:  v_cfg.sync_last  <= wdata;
                SEL_FETCH:    fetch_pos        <= wdata;
                SEL_SYNC:     sync_q           <= wdata;
                SEL_OUT:      out_q            <= wdata;
                default: ;
            endcase
        end
    end

    assign run         = &run_q;
    assign sync_cfg    = unpack_sync(sync_q);
    assign force_blank = out_q[1];
endmodule

// File: rtl/dtg_axis_cnt.sv
module dtg_axis_cnt
    import dtg_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              advance,
    input  logic [DATA_W-1:0] last,
    output logic [CNT_W-1:0]  pos,
    output logic              at_end
);
    logic [DATA_W-1:0] pos_x;

    assign pos_x  = DATA_W'(pos);
    assign at_end = (pos_x >= last);

    always_ff @(posedge clk) begin
        if (rst || clear)
            pos <= '0;
        else if (advance)
            pos <= at_end ? '0 : pos + 1'b1;
    end
endmodule

// File: rtl/dtg_sync_out.sv
module dtg_sync_out
    import dtg_pkg::*;
(
    input  logic      run,
    input  logic [1:0] in_act,
    input  logic [1:0] in_sync,
    input  logic      fetch_hit,
    input  sync_cfg_t cfg,
    input  logic      force_blank,
    output logic      active,
    output logic      video_en,
    output logic      hsync,
    output logic      vsync,
    output logic      rgb_sync,
    output logic      prefetch
);
    logic hs_raw, vs_raw, hs_kill, vs_kill;

    always_comb begin
        hs_raw   = run & in_sync[0];
        vs_raw   = run & in_sync[1];
        hs_kill  = cfg.all_off | cfg.hs_off;
        vs_kill  = cfg.all_off | cfg.vs_off;
        hsync    = hs_kill ? cfg.hs_inv : (hs_raw ^ cfg.hs_inv);
        vsync    = vs_kill ? cfg.vs_inv : (vs_raw ^ cfg.vs_inv);
        rgb_sync = cfg.rgb_en & ((hs_raw & ~hs_kill) | (vs_raw & ~vs_kill));
        active   = run & in_act[0] & in_act[1];
        video_en = active & ~force_blank;
        prefetch = run & fetch_hit;
    end
endmodule

// File: rtl/dtg_top.sv
module dtg_top
    import dtg_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [3:0]       reg_addr,
    input  logic [15:0]      reg_wdata,
    output logic [CNT_W-1:0] h_pos,
    output logic [CNT_W-1:0] v_pos,
    output logic             active,
    output logic             video_en,
    output logic             hsync,
    output logic             vsync,
    output logic             rgb_sync,
    output logic             prefetch
);
    localparam int AXES = 2;

    logic              run;
    axis_cfg_t         h_cfg, v_cfg;
    logic [DATA_W-1:0] fetch_pos;
    sync_cfg_t         sync_cfg;
    logic              force_blank;

    axis_cfg_t                     cfg_a [AXES];
    logic [AXES-1:0][CNT_W-1:0]    pos_a;
    logic [AXES-1:0]               end_a, adv_a, act_a, syn_a;
    logic [DATA_W-1:0]             h_last;

    dtg_regs u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .run(run), .h_cfg(h_cfg), .v_cfg(v_cfg), .fetch_pos(fetch_pos),
        .sync_cfg(sync_cfg), .force_blank(force_blank)
    );

    assign cfg_a[0] = h_cfg;
    assign cfg_a[1] = v_cfg;
    assign adv_a[0] = run;
    assign adv_a[1] = run & end_a[0];
    assign h_last   = h_cfg.last;

    for (genvar a = 0; a < AXES; a++) begin : g_axis
        logic [DATA_W-1:0] p_x;

        dtg_axis_cnt #(.CNT_W(CNT_W)) u_cnt (
            .clk(clk), .rst(rst), .clear(~run), .advance(adv_a[a]),
            .last(cfg_a[a].last), .pos(pos_a[a]), .at_end(end_a[a])
        );

        assign p_x      = DATA_W'(pos_a[a]);
        assign act_a[a] = (p_x <= cfg_a[a].act_last);
        assign syn_a[a] = in_span(p_x, cfg_a[a].sync_first, cfg_a[a].sync_last);
    end

    dtg_sync_out u_out (
        .run(run), .in_act(act_a), .in_sync(syn_a),
        .fetch_hit(DATA_W'(pos_a[0]) == fetch_pos),
        .cfg(sync_cfg), .force_blank(force_blank),
        .active(active), .video_en(video_en), .hsync(hsync), .vsync(vsync),
        .rgb_sync(rgb_sync), .prefetch(prefetch)
    );

    assign h_pos = pos_a[0];
    assign v_pos = pos_a[1];
endmodule

// File: rtl/dtg_checker.sv
module dtg_checker #(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             run,
    input logic [CNT_W-1:0] h_pos,
    input logic [CNT_W-1:0] v_pos,
    input logic [15:0]      h_last,
    input logic             prefetch,
    input logic             active,
    input logic             video_en,
    input logic             hsync,
    input logic             vsync,
    input logic             all_off,
    input logic             hs_inv,
    input logic             vs_inv
);
    assert_stop_clears_R2: assert property (@(posedge clk) disable iff (rst)
        !run |=> (h_pos == '0) && (v_pos == '0));

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !run |-> !active && !prefetch);

    assert_h_return_R3: assert property (@(posedge clk) disable iff (rst)
        run && (16'(h_pos) >= h_last) |=> (h_pos == '0));

    assert_v_step_R3: assert property (@(posedge clk) disable iff (rst)
        run && $past(run) && (v_pos != $past(v_pos)) |-> (16'($past(h_pos)) >= $past(h_last)));

    assert_fetch_single_R6: assert property (@(posedge clk) disable iff (rst)
        run && prefetch && (h_last != '0) |=> !prefetch);

    assert_blank_gate_R10: assert property (@(posedge clk) disable iff (rst)
        video_en |-> active);

    assert_all_off_R8: assert property (@(posedge clk) disable iff (rst)
        all_off |-> (hsync == hs_inv) && (vsync == vs_inv));
endmodule

bind dtg_top dtg_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .run(run), .h_pos(h_pos), .v_pos(v_pos),
    .h_last(h_last), .prefetch(prefetch), .active(active), .video_en(video_en),
    .hsync(hsync), .vsync(vsync), .all_off(sync_cfg.all_off),
    .hs_inv(sync_cfg.hs_inv), .vs_inv(sync_cfg.vs_inv)
);

// File: tb/dtg_top_bench.sv
module dtg_top_bench;
    localparam int CNT_W = 12;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             reg_we = 1'b0;
    logic [3:0]       reg_addr = '0;
    logic [15:0]      reg_wdata = '0;
    logic [CNT_W-1:0] h_pos, v_pos;
    logic active, video_en, hsync, vsync, rgb_sync, prefetch;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dtg_top #(.CNT_W(CNT_W)) u_dtg_top (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .h_pos(h_pos), .v_pos(v_pos), .active(active),
        .video_en(video_en), .hsync(hsync), .vsync(vsync),
        .rgb_sync(rgb_sync), .prefetch(prefetch)
    );

    // mode: 20 pixels x 10 lines, active 12x6, hs 13..15, vs 6..7, fetch at 17
    typedef struct packed {
        int unsigned  dly;
        logic [11:0]  h;
        logic [11:0]  v;
        logic         act;
        logic         hs;
        logic         vs;
        logic         pf;
    } vec_t;

    localparam int NVEC = 15;
    localparam vec_t VECS [NVEC] = '{
        '{dly: 0,   h: 0,  v: 0, act: 1, hs: 0, vs: 0, pf: 0},
        '{dly: 11,  h: 11, v: 0, act: 1, hs: 0, vs: 0, pf: 0},
        '{dly: 1,   h: 12, v: 0, act: 0, hs: 0, vs: 0, pf: 0},
        '{dly: 1,   h: 13, v: 0, act: 0, hs: 1, vs: 0, pf: 0},
        '{dly: 2,   h: 15, v: 0, act: 0, hs: 1, vs: 0, pf: 0},
        '{dly: 1,   h: 16, v: 0, act: 0, hs: 0, vs: 0, pf: 0},
        '{dly: 1,   h: 17, v: 0, act: 0, hs: 0, vs: 0, pf: 1},
        '{dly: 1,   h: 18, v: 0, act: 0, hs: 0, vs: 0, pf: 0},
        '{dly: 1,   h: 19, v: 0, act: 0, hs: 0, vs: 0, pf: 0},
        '{dly: 1,   h: 0,  v: 1, act: 1, hs: 0, vs: 0, pf: 0},
        '{dly: 100, h: 0,  v: 6, act: 0, hs: 0, vs: 1, pf: 0},
        '{dly: 35,  h: 15, v: 7, act: 0, hs: 1, vs: 1, pf: 0},
        '{dly: 5,   h: 0,  v: 8, act: 0, hs: 0, vs: 0, pf: 0},
        '{dly: 39,  h: 19, v: 9, act: 0, hs: 0, vs: 0, pf: 0},
        '{dly: 1,   h: 0,  v: 0, act: 1, hs: 0, vs: 0, pf: 0}
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // stop, set sync/output config, start again at position zero
    task automatic restart(input logic [15:0] scfg, input logic [15:0] ocfg);
        wr(4'd0, 16'd0);
        step(1);
        wr(4'd10, scfg);
        wr(4'd11, ocfg);
        wr(4'd0, 16'd3);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        // R1 reset state
        chk("R1 h_pos", 32'(h_pos), 0);
        chk("R1 v_pos", 32'(v_pos), 0);
        chk("R1 outputs", {active, video_en, hsync, vsync, rgb_sync, prefetch}, 0);

        wr(4'd1, 16'd19); wr(4'd2, 16'd11); wr(4'd3, 16'd13); wr(4'd4, 16'd15);
        wr(4'd5, 16'd9);  wr(4'd6, 16'd5);  wr(4'd7, 16'd6);  wr(4'd8, 16'd7);
        wr(4'd9, 16'd17);
        step(4);
        chk("R2 held before run", 32'(h_pos), 0);
        wr(4'd0, 16'd3);

        // table walk: R3 R4 R5 R6
        for (int i = 0; i < NVEC; i++) begin
            step(int'(VECS[i].dly));
            chk("R3 h_pos", 32'(h_pos), 32'(VECS[i].h));
            chk("R3 v_pos", 32'(v_pos), 32'(VECS[i].v));
            chk("R4 active", 32'(active), 32'(VECS[i].act));
            chk("R5 hsync", 32'(hsync), 32'(VECS[i].hs));
            chk("R5 vsync", 32'(vsync), 32'(VECS[i].vs));
            chk("R6 prefetch", 32'(prefetch), 32'(VECS[i].pf));
        end

        // R2: one enable bit alone does not run
        wr(4'd0, 16'd1);
        step(1);
        chk("R2 enable only h", 32'(h_pos), 0);
        step(5);
        chk("R2 enable only stays", 32'({h_pos, v_pos}), 0);
        chk("R2 idle active", 32'(active), 0);
        wr(4'd0, 16'd2);
        step(5);
        chk("R2 refresh only", 32'({h_pos, v_pos}), 0);

        // R7 inversion
        restart(16'h0008, 16'h0);
        chk("R7 hsync idle inverted", 32'(hsync), 1);
        step(13);
        chk("R7 hsync active inverted", 32'(hsync), 0);
        step(3);
        chk("R7 hsync after window", 32'(hsync), 1);
        restart(16'h0010, 16'h0);
        chk("R7 vsync idle inverted", 32'(vsync), 1);
        step(120);
        chk("R7 vsync active inverted", 32'(vsync), 0);

        // R8 suppression
        restart(16'h0020, 16'h0);
        step(13);
        chk("R8 hsync suppressed", 32'(hsync), 0);
        step(107);
        chk("R8 vsync kept", 32'(vsync), 1);
        restart(16'h0040, 16'h0);
        step(120);
        chk("R8 vsync suppressed", 32'(vsync), 0);
        step(15);
        chk("R8 hsync kept", 32'(hsync), 1);
        restart(16'h001A, 16'h0);
        step(135);
        chk("R8 all off h", 32'(hsync), 1);
        chk("R8 all off v", 32'(vsync), 1);

        // R9 sync on colour channels
        restart(16'h0001, 16'h0);
        chk("R9 rgb idle", 32'(rgb_sync), 0);
        step(13);
        chk("R9 rgb on hsync", 32'(rgb_sync), 1);
        step(107);
        chk("R9 rgb on vsync", 32'(rgb_sync), 1);
        restart(16'h0003, 16'h0);
        step(13);
        chk("R9 rgb with all off", 32'(rgb_sync), 0);
        restart(16'h0000, 16'h0);
        step(13);
        chk("R9 rgb disabled", 32'(rgb_sync), 0);

        // R10 forced blank
        restart(16'h0000, 16'h0002);
        chk("R10 active under blank", 32'(active), 1);
        chk("R10 video blanked", 32'(video_en), 0);
        step(13);
        chk("R10 hsync continues", 32'(hsync), 1);
        restart(16'h0000, 16'h0000);
        chk("R10 video on", 32'(video_en), 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule